// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Stop Length

This block sends 8-bit characters as asynchronous serial frames on a single output line. A character enters through a valid/ready handshake. The block then sends one start bit at the active level, then the eight data bits with the least significant bit first, then a stop period at the idle level. Every bit lasts a fixed number of ticks of an oversampled baud strobe. The baud strobe comes from outside the block. With the default of 16 ticks per bit, a frame is 144 ticks plus the stop period.

The stop period can be one, one and a half, or two bit times. A polarity control inverts every level the line carries, including the idle level, so the line can drive an inverting transceiver directly. While a frame is in progress the block reports busy and refuses new characters.

Top module: `serial_tx_frac_stop`

## Requirements
- R1: After reset, with no character offered, busy is 0, in_ready is 1 and tx_line rests at the idle level.
- R2: When a character is accepted, the start bit appears on tx_line in the next cycle at the active (non-idle) level and lasts 16 baud ticks.
- R3: The 8 data bits follow the start bit, bit 0 first. Each bit lasts 16 baud ticks.
- R4: With stop_mode 2'b00 the stop period lasts 16 ticks, so the whole frame takes 160 ticks.
- R5: With stop_mode 2'b01 the stop period lasts 24 ticks (one and a half bits), so the frame takes 168 ticks.
- R6: With stop_mode 2'b10 or 2'b11 the stop period lasts 32 ticks, so the frame takes 176 ticks.
- R7: With invert = 0, the idle level and the stop bits are high, the start bit is low, and data bits go out unchanged.
- R8: With invert = 1, every level on tx_line is the complement of the invert = 0 case: the idle level is low, the start bit is high, and the data bits are complemented.
- R9: in_ready is low and busy is high from the cycle after acceptance until the stop period ends. If in_valid is asserted during that time, the offered data is not sent.
- R10: stop_mode is captured when a character is accepted. Changing stop_mode during the frame has no effect on that frame.
- R11: tx_line changes only on baud ticks. If ticks are sparse, each level is held for the same number of ticks as when they are dense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle oversampling strobe, 16 per bit |
| stop_mode | input | 2 | Stop length select: 00 one, 01 one and a half, 10/11 two bits |
| invert | input | 1 | 1 inverts the whole output line including idle |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
The bench sends frames with ticks on every cycle and with ticks every third cycle. The sparse case separates tick counting from cycle counting. Each stop mode is used with a bit pattern that alternates and with patterns whose end bits are set. This exposes bit-order mistakes and stop lengths that are off by half a bit. A frame with invert set shows whether the idle level is inverted along with the data. The bench also offers a character during a frame and changes stop_mode during a frame. These two cases show whether inputs are sampled only at acceptance.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } stx_state_e;

  // Length in baud ticks of the stop period for a given mode.
  function automatic int unsigned stop_ticks(input logic [1:0] mode,
                                             input int unsigned ovs);
    case (mode)
      2'b00:   return ovs;
      2'b01:   return ovs + ovs / 2;
      default: return 2 * ovs;
    endcase
  endfunction

endpackage

// File: rtl/stx_phase_timer.sv
module stx_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  assign last = tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || last) cnt <= '0;
    else if (tick)               cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/stx_shift_reg.sv
module stx_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         lsb
);

  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign lsb = sh_q[0];

endmodule

// File: rtl/serial_tx_frac_stop.sv
module serial_tx_frac_stop #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [1:0]        stop_mode,
  input  logic              invert,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx_line,
  output logic              busy
);
  import stx_pkg::*;

  localparam int CNT_W = $clog2(2 * OVS + 1);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  stx_state_e       state;
  logic [1:0]       mode_q;
  logic [IDX_W-1:0] bit_idx;
  logic [CNT_W-1:0] phase_len;
  logic [CNT_W-1:0] tick_cnt;

  // Named internal events
  logic accept;
  logic phase_done;
  logic data_shift;
  logic frame_done;
  logic raw_level;

  assign busy       = (state != ST_IDLE);
  assign in_ready   = !busy;
  assign accept     = in_valid && in_ready;
  assign data_shift = phase_done && (state == ST_DATA);
  assign frame_done = phase_done && (state == ST_STOP);

  always_comb begin
    if (state == ST_STOP) phase_len = CNT_W'(stop_ticks(mode_q, OVS));
    else                  phase_len = CNT_W'(OVS);
  end

  stx_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .tick  (baud_tick && busy),
    .limit (phase_len),
    .cnt   (tick_cnt),
    .last  (phase_done)
  );

  logic data_lsb;

  stx_shift_reg #(.W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (data_shift),
    .din   (in_data),
    .lsb   (data_lsb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_q  <= 2'b00;
      bit_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_START;
          mode_q <= stop_mode;
        end
        ST_START: if (phase_done) begin
          state   <= ST_DATA;
          bit_idx <= '0;
        end
        ST_DATA: if (phase_done) begin
          if (bit_idx == LAST_IDX) state <= ST_STOP;
          else                     bit_idx <= bit_idx + 1'b1;
        end
        ST_STOP: if (phase_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: raw_level = 1'b0;
      ST_DATA:  raw_level = data_lsb;
      default:  raw_level = 1'b1;
    endcase
  end

  assign tx_line = raw_level ^ invert;

endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             invert,
  input logic             busy,
  input logic             tx_line,
  input logic             accept,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] tick_cnt,
  input logic [CNT_W-1:0] phase_len
);

  p_start_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tx_line == invert));

  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_line == !invert));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(mode_q));

  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> ((tx_line == $past(tx_line)) || (invert != $past(invert))));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tick_cnt < phase_len));

endmodule

bind serial_tx_frac_stop stx_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .invert    (invert),
  .busy      (busy),
  .tx_line   (tx_line),
  .accept    (accept),
  .mode_q    (mode_q),
  .tick_cnt  (tick_cnt),
  .phase_len (phase_len)
);

// File: tb/tb_serial_tx_frac_stop.sv
module tb_serial_tx_frac_stop;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] stop_mode = 2'b00;
  logic       invert = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready, tx_line, busy;

  int n_chk = 0;
  int n_fail = 0;
  int gap = 1;
  int tick_ctr = 0;
  string note = "";

  serial_tx_frac_stop dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .stop_mode(stop_mode),
    .invert(invert), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tx_line(tx_line), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Baud strobe: one pulse every gap cycles
  always @(negedge clk) begin
    if (tick_ctr + 1 >= gap) begin baud_tick = 1'b1; tick_ctr = 0; end
    else begin baud_tick = 1'b0; tick_ctr++; end
  end

  // Reference model: queue of levels, one entry per tick
  bit q[$];
  int model_len = 0;
  int model_mode = 0;
  logic [7:0] model_byte = 8'h00;
  bit busy_s = 1'b0;
  int dut_ticks = 0;

  function automatic int exp_stop(input int m);
    if (m == 0) return 16;
    if (m == 1) return 24;
    return 32;
  endfunction

  always @(posedge clk) begin
    if (busy_s && baud_tick) dut_ticks++;
    if (!rst_n) q.delete();
    else if (q.size() == 0) begin
      if (in_valid) begin
        model_mode = int'(stop_mode);
        model_byte = in_data;
        model_len  = 144 + exp_stop(model_mode);
        for (int i = 0; i < 16; i++) q.push_back(1'b0);
        for (int b = 0; b < 8; b++)
          for (int i = 0; i < 16; i++) q.push_back(in_data[b]);
        for (int i = 0; i < exp_stop(model_mode); i++) q.push_back(1'b1);
      end
    end else if (baud_tick) void'(q.pop_front());
  end

  // Per-cycle comparison and frame monitor, sampled mid-cycle
  logic [7:0] dec = 8'h00;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      automatic bit exp_raw  = (q.size() != 0) ? q[0] : 1'b1;
      automatic bit exp_busy = (q.size() != 0);
      chk(tx_line == (exp_raw ^ invert), invert ? "R8 line level" : "R7 line level",
          tx_line, exp_raw ^ invert);
      chk(busy == exp_busy, "R9 busy", busy, exp_busy);
      chk(in_ready == !exp_busy, "R9 in_ready", in_ready, !exp_busy);
      if (!busy_s && busy) begin
        dut_ticks = 0;
        chk(tx_line == invert, "R2 start level", tx_line, invert);
      end
      if (busy && dut_ticks >= 16 && dut_ticks < 144 && ((dut_ticks - 16) % 16) == 8)
        dec[(dut_ticks - 16) / 16] = tx_line ^ invert;
      if (busy_s && !busy) begin
        chk(dut_ticks == model_len,
            (model_mode == 0) ? {"R4 frame ticks ", note} :
            (model_mode == 1) ? {"R5 frame ticks ", note} : {"R6 frame ticks ", note},
            dut_ticks, model_len);
        chk(dec == model_byte, {"R3 decoded byte ", note}, dec, model_byte);
      end
      busy_s = busy;
    end
  end

  task automatic send(input logic [7:0] b, input logic [1:0] m);
    do @(negedge clk); while (!in_ready);
    in_data = b; stop_mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1: reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(tx_line == 1'b1, "R1 idle level", tx_line, 1);

    note = "dense";
    send(8'hA5, 2'b00);
    send(8'h3C, 2'b01);
    send(8'h81, 2'b10);
    send(8'hFF, 2'b11);

    note = "R11 sparse ticks";
    gap = 3;
    send(8'h5A, 2'b01);
    send(8'h01, 2'b00);
    gap = 1;

    note = "R8 inverted";
    invert = 1'b1;
    repeat (2) @(negedge clk);
    #2 chk(tx_line == 1'b0, "R8 idle low", tx_line, 0);
    send(8'hC3, 2'b01);
    invert = 1'b0;

    // R9: offer during a frame, must not be sent
    note = "R9 offer while busy";
    do @(negedge clk); while (!in_ready);
    in_data = 8'h96; stop_mode = 2'b00; in_valid = 1'b1;
    @(negedge clk);
    in_data = 8'hEE;
    repeat (40) @(negedge clk);
    in_valid = 1'b0;
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);

    // R10: stop_mode changed mid-frame
    note = "R10 mode changed";
    do @(negedge clk); while (!in_ready);
    in_data = 8'h6B; stop_mode = 2'b01; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    stop_mode = 2'b10;
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule